// File: doc/BRIEF.md
# Effective Address Sequencer for an 8-bit CPU Core

This block sits between instruction fetch and execute in a small 8-bit processor. When the fetch stage has the opcode byte and the program counter of the byte that follows it, it pulses `start`. The sequencer classifies the opcode into one of thirteen addressing modes. It then walks memory one byte read at a time to collect the operand bytes, follows any pointer bytes, and forms the 16-bit effective address. Where the mode calls for it, it also fetches the operand byte held at that address. It reports the results with a one-cycle `done` pulse.

The memory port is a plain synchronous read port. The block drives `mem_rd` and `mem_addr` in a cycle, and the memory must present the byte on `mem_rdata` in the very next cycle. The port has no back-pressure: the memory can never stall the sequencer, so a slower memory needs a wrapper that holds the whole core. The `start` input is a plain strobe, not a handshake. It is taken only while the block is idle, and a pulse at any other time is dropped without effect.

All results are registered. `eff_addr`, `operand`, `pc_out` and `mode_out` are valid in the cycle `done` is high, and they hold their values until the next accepted `start`.

Top module: `ea_sequencer`

## Requirements
- R1: `mode_out` carries the decoded mode with this code: 0 invalid, 1 implied, 2 accumulator, 3 immediate, 4 zero page, 5 zero page + X, 6 zero page + Y, 7 absolute, 8 absolute + X, 9 absolute + Y, 10 absolute indirect, 11 X-indexed indirect, 12 indirect Y-indexed, 13 relative.
  - The opcode map is the standard one for this CPU family. For example, 0x6C decodes to 10, 0x96 and 0xB6 to 6, 0xBE to 9, 0xA2 to 3, and 0x0A to 2.
  - Every opcode with low nibble 0 and an odd high nibble decodes to 13.
  - Opcodes outside the map decode to 0.
- R2: For implied and invalid opcodes:
  - `done` is high in the first cycle after the accepting edge.
  - No memory read is made.
  - `eff_addr` and `operand` are 0, and `pc_out` equals `pc_in`.
- R3: For accumulator mode:
  - `done` is high in the first cycle after the accepting edge.
  - No read is made.
  - `operand` equals `acc_in`, `eff_addr` is 0, and `pc_out` equals `pc_in`.
- R4: For immediate mode:
  - The block makes one read at `pc_in`, and that byte is the operand.
  - `eff_addr` is 0 and `pc_out` is `pc_in`+1 (mod 65536).
  - `done` is high in the third cycle after the accepting edge.
- R5: For the zero-page modes:
  - The block reads byte b at `pc_in`.
  - The effective address is (b + index) mod 256 with the high byte 0. The index is 0, X or Y by mode, and no carry reaches the high byte.
  - The operand is read from the effective address, and `pc_out` is `pc_in`+1.
  - `done` is high in the fifth cycle.
- R6: For the absolute modes:
  - The block reads the low byte at `pc_in`, then the high byte at `pc_in`+1.
  - The effective address is the 16-bit base plus the index (0, X or Y), mod 65536.
  - The operand is read from the effective address, and `pc_out` is `pc_in`+2.
  - `done` is high in the sixth cycle.
- R7: For absolute indirect mode:
  - The block reads a little-endian pointer address p at `pc_in` and `pc_in`+1.
  - The effective address is read low byte first from p, then high byte from p+1. That address is a full 16-bit increment, so it may cross a page.
  - The operand is read from the effective address, and `pc_out` is `pc_in`+2.
  - `done` is high in the ninth cycle.
- R8: For X-indexed indirect mode:
  - The block reads byte b at `pc_in` and forms t = (b + X) mod 256.
  - The effective address is read little-endian from t and (t+1) mod 256.
  - The operand is read from the effective address, and `pc_out` is `pc_in`+1.
  - `done` is high in the eighth cycle.
- R9: For indirect Y-indexed mode:
  - The block reads byte b at `pc_in`, then a pointer from b and (b+1) mod 256.
  - The effective address is pointer + Y, mod 65536.
  - The operand is read from the effective address, and `pc_out` is `pc_in`+1.
  - `done` is high in the eighth cycle.
- R10: For relative mode:
  - The block reads offset byte d at `pc_in`.
  - The effective address is (`pc_in` + 1 + d as a signed two's-complement value) mod 65536. Bit 7 set means a negative displacement.
  - The operand is d, and `pc_out` is `pc_in`+1.
  - `done` is high in the third cycle.
- R11: Reads follow these rules:
  - At most one read is made per cycle, only at the addresses listed above, and in the listed order.
  - `done` is a single-cycle pulse with no read in its cycle.
  - Results hold until the next accepted start.
  - After reset, `done` and `mem_rd` are low, and `eff_addr` and `operand` are 0.
- R12: A `start` pulse while a sequence is in progress is ignored. The running sequence's reads and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| opcode | input | 8 | Instruction opcode, sampled with start |
| pc_in | input | 16 | Address of the byte after the opcode |
| acc_in | input | 8 | Accumulator value, sampled with start |
| x_in | input | 8 | X index, sampled with start |
| y_in | input | 8 | Y index, sampled with start |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle pulse: results valid |
| pc_out | output | 16 | PC after the operand bytes |
| eff_addr | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| mode_out | output | 4 | Decoded mode code (R1) |

## Verification
The bench steps through every one of the 256 opcodes. It then drives directed cases at the places where the arithmetic has to wrap:
- an X-indexed zero-page sum passing 0xFF;
- a pointer fetch at 0xFF whose second byte must come from 0x00, not 0x100;
- a Y-indexed pointer sum carrying into the high byte;
- an absolute + X address wrapping past 0xFFFF;
- an indirect pointer at a page end;
- negative and wrapping branch offsets.

A design that lets a zero-page sum carry would read page one, and one that misses the Y carry would report the wrong page. A design that sign-extends wrongly would send a backward branch far forward. A design that miscounts states would show `done` in the wrong cycle. Pokes on `start` in mid-sequence catch a design that restarts and so loses or repeats reads.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int EA_ADDR_W = 16;
  parameter int EA_DATA_W = 8;

  typedef enum logic [3:0] {
    M_INVALID   = 4'd0,
    M_IMPLIED   = 4'd1,
    M_ACCUM     = 4'd2,
    M_IMMED     = 4'd3,
    M_ZPAGE     = 4'd4,
    M_ZPAGE_X   = 4'd5,
    M_ZPAGE_Y   = 4'd6,
    M_ABSOL     = 4'd7,
    M_ABSOL_X   = 4'd8,
    M_ABSOL_Y   = 4'd9,
    M_INDIRECT  = 4'd10,
    M_PRE_X_IND = 4'd11,
    M_IND_POST_Y= 4'd12,
    M_RELATIVE  = 4'd13
  } ea_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH_LO,
    S_FETCH_HI,
    S_OPND_GOT,
    S_PTR_LO,
    S_PTR_HI,
    S_PTR_GOT,
    S_DATA_RD,
    S_DATA_GOT,
    S_DONE
  } ea_state_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output ea_mode_e        mode
);
  localparam int NIB = OP_W / 2;

  logic [NIB-1:0] hi;
  logic [NIB-1:0] lo;
  logic           odd_row;
  logic           row_9_or_b;

  assign hi         = op[OP_W-1:NIB];
  assign lo         = op[NIB-1:0];
  assign odd_row    = hi[0];
  assign row_9_or_b = (hi == 4'h9) || (hi == 4'hB);

  always_comb begin
    mode = M_INVALID;
    case (lo)
      4'h0: begin
        if (odd_row) mode = M_RELATIVE;
        else begin
          case (hi)
            4'h0, 4'h4, 4'h6: mode = M_IMPLIED;
            4'h2:             mode = M_ABSOL;
            4'hA, 4'hC, 4'hE: mode = M_IMMED;
            default:          mode = M_INVALID;
          endcase
        end
      end
      4'h1: mode = odd_row ? M_IND_POST_Y : M_PRE_X_IND;
      4'h2: mode = (hi == 4'hA) ? M_IMMED : M_INVALID;
      4'h4: begin
        if (odd_row) mode = row_9_or_b ? M_ZPAGE_X : M_INVALID;
        else if (hi == 4'h2 || hi[3]) mode = M_ZPAGE;
        else mode = M_INVALID;
      end
      4'h5: mode = odd_row ? M_ZPAGE_X : M_ZPAGE;
      4'h6: begin
        if (!odd_row) mode = M_ZPAGE;
        else mode = row_9_or_b ? M_ZPAGE_Y : M_ZPAGE_X;
      end
      4'h8: mode = M_IMPLIED;
      4'h9: begin
        if (odd_row) mode = M_ABSOL_Y;
        else mode = (hi == 4'h8) ? M_INVALID : M_IMMED;
      end
      4'hA: begin
        if (odd_row) mode = row_9_or_b ? M_IMPLIED : M_INVALID;
        else mode = hi[3] ? M_IMPLIED : M_ACCUM;
      end
      4'hC: begin
        if (odd_row) mode = (hi == 4'hB) ? M_ABSOL_X : M_INVALID;
        else if (hi == 4'h6) mode = M_INDIRECT;
        else if (hi == 4'h0) mode = M_INVALID;
        else mode = M_ABSOL;
      end
      4'hD: mode = odd_row ? M_ABSOL_X : M_ABSOL;
      4'hE: begin
        if (!odd_row) mode = M_ABSOL;
        else if (hi == 4'h9) mode = M_INVALID;
        else if (hi == 4'hB) mode = M_ABSOL_Y;
        else mode = M_ABSOL_X;
      end
      default: mode = M_INVALID;
    endcase
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int DATA_W = EA_DATA_W
) (
  input  ea_mode_e          mode,
  input  logic [DATA_W-1:0] cur_byte,
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  input  logic [ADDR_W-1:0] pc_base,
  input  logic [ADDR_W-1:0] ptr,
  output logic              needs_hi,
  output logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] direct_ea,
  output logic [ADDR_W-1:0] ptr_first,
  output logic [ADDR_W-1:0] ptr_second,
  output logic [ADDR_W-1:0] ind_ea
);
  localparam int PAD = ADDR_W - DATA_W;

  logic [DATA_W-1:0] idx;
  logic [DATA_W-1:0] zp_sum;
  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] rel_disp;
  logic              zp_pointer;

  always_comb begin
    case (mode)
      M_ZPAGE_X, M_ABSOL_X, M_PRE_X_IND: idx = x_val;
      M_ZPAGE_Y, M_ABSOL_Y, M_IND_POST_Y: idx = y_val;
      default:                           idx = '0;
    endcase
  end

  assign zp_sum     = cur_byte + idx;
  assign word       = {cur_byte, lo_byte};
  assign rel_disp   = {{PAD{cur_byte[DATA_W-1]}}, cur_byte};
  assign needs_hi   = (mode == M_ABSOL) || (mode == M_ABSOL_X) ||
                      (mode == M_ABSOL_Y) || (mode == M_INDIRECT);
  assign pc_next    = pc_base + (needs_hi ? ADDR_W'(2) : ADDR_W'(1));
  assign zp_pointer = (mode == M_PRE_X_IND) || (mode == M_IND_POST_Y);

  always_comb begin
    case (mode)
      M_ZPAGE, M_ZPAGE_X, M_ZPAGE_Y: direct_ea = {{PAD{1'b0}}, zp_sum};
      M_RELATIVE:                    direct_ea = pc_base + ADDR_W'(1) + rel_disp;
      default:                       direct_ea = word + {{PAD{1'b0}}, idx};
    endcase
  end

  always_comb begin
    if (mode == M_INDIRECT) ptr_first = word;
    else if (mode == M_PRE_X_IND) ptr_first = {{PAD{1'b0}}, zp_sum};
    else ptr_first = {{PAD{1'b0}}, cur_byte};
  end

  always_comb begin
    if (zp_pointer) ptr_second = {{PAD{1'b0}}, ptr[DATA_W-1:0] + DATA_W'(1)};
    else ptr_second = ptr + ADDR_W'(1);
  end

  assign ind_ea = (mode == M_IND_POST_Y) ? word + {{PAD{1'b0}}, y_val} : word;
endmodule

// File: rtl/ea_seq_fsm.sv
module ea_seq_fsm
  import ea_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int DATA_W = EA_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ea_mode_e          mode_dec,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] operand,
  output ea_mode_e          mode_out
);
  ea_state_e         state;
  ea_mode_e          mode_r;
  logic [ADDR_W-1:0] pc_r, pc_out_r, ptr_r, ea_r;
  logic [DATA_W-1:0] a_r, x_r, y_r, lo_r, opnd_r;

  logic              needs_hi;
  logic [ADDR_W-1:0] pc_next, direct_ea, ptr_first, ptr_second, ind_ea;

  ea_addr_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
    .mode      (mode_r),
    .cur_byte  (mem_rdata),
    .lo_byte   (lo_r),
    .x_val     (x_r),
    .y_val     (y_r),
    .pc_base   (pc_r),
    .ptr       (ptr_r),
    .needs_hi  (needs_hi),
    .pc_next   (pc_next),
    .direct_ea (direct_ea),
    .ptr_first (ptr_first),
    .ptr_second(ptr_second),
    .ind_ea    (ind_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_r   <= M_INVALID;
      pc_r     <= '0;
      pc_out_r <= '0;
      ptr_r    <= '0;
      ea_r     <= '0;
      a_r      <= '0;
      x_r      <= '0;
      y_r      <= '0;
      lo_r     <= '0;
      opnd_r   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_r   <= mode_dec;
            pc_r     <= pc_in;
            pc_out_r <= pc_in;
            a_r      <= acc_in;
            x_r      <= x_in;
            y_r      <= y_in;
            ea_r     <= '0;
            opnd_r   <= '0;
            case (mode_dec)
              M_IMPLIED, M_INVALID: state <= S_DONE;
              M_ACCUM: begin
                opnd_r <= acc_in;
                state  <= S_DONE;
              end
              default: state <= S_FETCH_LO;
            endcase
          end
        end
        S_FETCH_LO: state <= needs_hi ? S_FETCH_HI : S_OPND_GOT;
        S_FETCH_HI: begin
          lo_r  <= mem_rdata;
          state <= S_OPND_GOT;
        end
        S_OPND_GOT: begin
          pc_out_r <= pc_next;
          case (mode_r)
            M_IMMED: begin
              opnd_r <= mem_rdata;
              state  <= S_DONE;
            end
            M_RELATIVE: begin
              opnd_r <= mem_rdata;
              ea_r   <= direct_ea;
              state  <= S_DONE;
            end
            M_INDIRECT, M_PRE_X_IND, M_IND_POST_Y: begin
              ptr_r <= ptr_first;
              state <= S_PTR_LO;
            end
            default: begin
              ea_r  <= direct_ea;
              state <= S_DATA_RD;
            end
          endcase
        end
        S_PTR_LO: state <= S_PTR_HI;
        S_PTR_HI: begin
          lo_r  <= mem_rdata;
          state <= S_PTR_GOT;
        end
        S_PTR_GOT: begin
          ea_r  <= ind_ea;
          state <= S_DATA_RD;
        end
        S_DATA_RD: state <= S_DATA_GOT;
        S_DATA_GOT: begin
          opnd_r <= mem_rdata;
          state  <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = 1'b1;
    mem_addr = '0;
    case (state)
      S_FETCH_LO: mem_addr = pc_r;
      S_FETCH_HI: mem_addr = pc_r + ADDR_W'(1);
      S_PTR_LO:   mem_addr = ptr_r;
      S_PTR_HI:   mem_addr = ptr_second;
      S_DATA_RD:  mem_addr = ea_r;
      default:    mem_rd   = 1'b0;
    endcase
  end

  assign done     = (state == S_DONE);
  assign pc_out   = pc_out_r;
  assign eff_addr = ea_r;
  assign operand  = opnd_r;
  assign mode_out = mode_r;

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_read_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);
  assert_fast_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && (mode_dec == M_IMPLIED || mode_dec == M_INVALID))
      |=> (done && eff_addr == '0 && operand == '0));
  assert_acc_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_out == M_ACCUM) |-> (eff_addr == '0 && operand == a_r));
  assert_imm_zero_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_out == M_IMMED) |-> (eff_addr == '0));
  assert_zp_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_out == M_ZPAGE || mode_out == M_ZPAGE_X || mode_out == M_ZPAGE_Y))
      |-> (eff_addr[ADDR_W-1:DATA_W] == '0));
  assert_ptr_in_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PTR_HI && mode_r != M_INDIRECT) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));
  assert_busy_mode_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(mode_out));
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int DATA_W = EA_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] operand,
  output logic [3:0]        mode_out
);
  ea_mode_e mode_dec;
  ea_mode_e mode_q;

  ea_mode_decode #(.OP_W(DATA_W)) u_decode (
    .op  (opcode),
    .mode(mode_dec)
  );

  ea_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_dec (mode_dec),
    .pc_in    (pc_in),
    .acc_in   (acc_in),
    .x_in     (x_in),
    .y_in     (y_in),
    .mem_rdata(mem_rdata),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .pc_out   (pc_out),
    .eff_addr (eff_addr),
    .operand  (operand),
    .mode_out (mode_q)
  );

  assign mode_out = mode_q;
endmodule

// File: tb/tb_ea_sequencer.sv
module tb_ea_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  acc_in = '0, x_in = '0, y_in = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [15:0] pc_out, eff_addr;
  logic [7:0]  operand;
  logic [3:0]  mode_out;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0]  ov[logic [15:0]];
  logic [15:0] exp_rd[$];

  ea_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .acc_in(acc_in), .x_in(x_in), .y_in(y_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .pc_out(pc_out), .eff_addr(eff_addr),
    .operand(operand), .mode_out(mode_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memv(input logic [15:0] a);
    logic [7:0] base;
    if (ov.exists(a)) return ov[a];
    base = a[7:0] * 8'd7;
    return base ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memv(mem_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_CYCLES) begin
      n_bad = n_bad + 1;
      $display("FAIL R11 watchdog expired: got %0d cycles expected below %0d", cyc, WDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Reference opcode map, listed by mode (R1 codes)
  function automatic int ref_mode(input logic [7:0] op);
    case (op)
      8'h00, 8'h40, 8'h60, 8'h08, 8'h18, 8'h28, 8'h38, 8'h48, 8'h58, 8'h68, 8'h78,
      8'h88, 8'h98, 8'hA8, 8'hB8, 8'hC8, 8'hD8, 8'hE8, 8'hF8,
      8'h8A, 8'h9A, 8'hAA, 8'hBA, 8'hCA, 8'hEA: return 1;
      8'h0A, 8'h2A, 8'h4A, 8'h6A: return 2;
      8'h09, 8'h29, 8'h49, 8'h69, 8'hA9, 8'hC9, 8'hE9,
      8'hA0, 8'hA2, 8'hC0, 8'hE0: return 3;
      8'h05, 8'h25, 8'h45, 8'h65, 8'h85, 8'hA5, 8'hC5, 8'hE5,
      8'h06, 8'h26, 8'h46, 8'h66, 8'h86, 8'hA6, 8'hC6, 8'hE6,
      8'h24, 8'h84, 8'hA4, 8'hC4, 8'hE4: return 4;
      8'h15, 8'h35, 8'h55, 8'h75, 8'h95, 8'hB5, 8'hD5, 8'hF5,
      8'h16, 8'h36, 8'h56, 8'h76, 8'hD6, 8'hF6, 8'h94, 8'hB4: return 5;
      8'h96, 8'hB6: return 6;
      8'h0D, 8'h2D, 8'h4D, 8'h6D, 8'h8D, 8'hAD, 8'hCD, 8'hED,
      8'h0E, 8'h2E, 8'h4E, 8'h6E, 8'h8E, 8'hAE, 8'hCE, 8'hEE,
      8'h2C, 8'h4C, 8'h8C, 8'hAC, 8'hCC, 8'hEC, 8'h20: return 7;
      8'h1D, 8'h3D, 8'h5D, 8'h7D, 8'h9D, 8'hBD, 8'hDD, 8'hFD,
      8'h1E, 8'h3E, 8'h5E, 8'h7E, 8'hDE, 8'hFE, 8'hBC: return 8;
      8'h19, 8'h39, 8'h59, 8'h79, 8'h99, 8'hB9, 8'hD9, 8'hF9, 8'hBE: return 9;
      8'h6C: return 10;
      8'h01, 8'h21, 8'h41, 8'h61, 8'h81, 8'hA1, 8'hC1, 8'hE1: return 11;
      8'h11, 8'h31, 8'h51, 8'h71, 8'h91, 8'hB1, 8'hD1, 8'hF1: return 12;
      8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0: return 13;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      7, 8, 9: return "R6";
      10: return "R7";
      11: return "R8";
      12: return "R9";
      13: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic run_one(input logic [7:0] op, input int pc, input int a, input int x,
                         input int y, input int poke);
    int m, lat, ea, opnd, npc, idx, b, p, t;
    string tg;
    m = ref_mode(op);
    tg = tag_of(m);
    exp_rd.delete();
    ea = 0; opnd = 0; npc = pc;
    idx = (m == 5 || m == 8) ? x : ((m == 6 || m == 9) ? y : 0);
    case (m)
      2: begin opnd = a; lat = 1; end
      3: begin exp_rd.push_back(16'(pc)); opnd = memv(16'(pc)); npc = (pc + 1) % 65536; lat = 3; end
      13: begin
        exp_rd.push_back(16'(pc)); b = memv(16'(pc)); opnd = b;
        ea = (pc + 1 + ((b >= 128) ? b - 256 : b) + 65536) % 65536;
        npc = (pc + 1) % 65536; lat = 3;
      end
      4, 5, 6: begin
        exp_rd.push_back(16'(pc)); t = (memv(16'(pc)) + idx) % 256;
        ea = t; exp_rd.push_back(16'(ea)); opnd = memv(16'(ea));
        npc = (pc + 1) % 65536; lat = 5;
      end
      7, 8, 9, 10: begin
        exp_rd.push_back(16'(pc)); exp_rd.push_back(16'((pc + 1) % 65536));
        p = memv(16'(pc)) + 256 * memv(16'((pc + 1) % 65536));
        npc = (pc + 2) % 65536;
        if (m == 10) begin
          exp_rd.push_back(16'(p)); exp_rd.push_back(16'((p + 1) % 65536));
          ea = memv(16'(p)) + 256 * memv(16'((p + 1) % 65536)); lat = 9;
        end else begin
          ea = (p + idx) % 65536; lat = 6;
        end
        exp_rd.push_back(16'(ea)); opnd = memv(16'(ea));
      end
      11, 12: begin
        exp_rd.push_back(16'(pc)); b = memv(16'(pc));
        t = (m == 11) ? (b + x) % 256 : b;
        exp_rd.push_back(16'(t)); exp_rd.push_back(16'((t + 1) % 256));
        p = memv(16'(t)) + 256 * memv(16'((t + 1) % 256));
        ea = (m == 12) ? (p + y) % 65536 : p;
        exp_rd.push_back(16'(ea)); opnd = memv(16'(ea));
        npc = (pc + 1) % 65536; lat = 8;
      end
      default: lat = 1;
    endcase

    @(negedge clk);
    opcode = op; pc_in = 16'(pc); acc_in = 8'(a); x_in = 8'(x); y_in = 8'(y); start = 1'b1;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke != 0 && k == poke) begin
        start = 1'b1; opcode = 8'hEA; pc_in = 16'h1234; acc_in = 8'h99;
      end
      if (mem_rd) begin
        if (exp_rd.size() == 0) chk(1'b0, "R11", "unexpected read address", int'(mem_addr), -1);
        else begin
          chk(mem_addr == exp_rd[0], (poke != 0) ? "R12" : "R11", "read address",
              int'(mem_addr), int'(exp_rd[0]));
          void'(exp_rd.pop_front());
        end
      end
      chk(done == (k == lat), tg, "done timing", int'(done), int'(k == lat));
      if (k == lat) begin
        chk(int'(mode_out) == m, "R1", $sformatf("mode of opcode %02h", op), int'(mode_out), m);
        chk(int'(eff_addr) == ea, tg, "effective address", int'(eff_addr), ea);
        chk(int'(operand) == opnd, tg, "operand", int'(operand), opnd);
        chk(int'(pc_out) == npc, tg, "updated pc", int'(pc_out), npc);
        chk(exp_rd.size() == 0, "R11", "reads left unmade", exp_rd.size(), 0);
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R11", "done is single pulse", int'(done), 0);
    chk(int'(eff_addr) == ea, "R11", "result held after done", int'(eff_addr), ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done, "R11", "reset done", int'(done), 0);
    chk(!mem_rd, "R11", "reset read strobe", int'(mem_rd), 0);
    chk(eff_addr == 16'h0 && operand == 8'h0, "R11", "reset results",
        int'(eff_addr) + int'(operand), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of the whole opcode space (R1 and every mode)
    for (int i = 0; i < 256; i++)
      run_one(8'(i), (i * 257 + 3) % 65536, (i * 3) % 256, i ^ 8'h5A, 255 - i, 0);

    // R5: zero page + X wraps within page zero
    ov[16'h0200] = 8'hF0;
    run_one(8'hB5, 16'h0200, 8'h00, 8'h20, 8'h00, 0);
    // R5: zero page + Y wraps to 0x00
    ov[16'h0300] = 8'h01;
    run_one(8'hB6, 16'h0300, 8'h00, 8'h00, 8'hFF, 0);
    // R8: pointer straddling 0xFF wraps to 0x00
    ov[16'h0400] = 8'hFE; ov[16'h00FF] = 8'h34; ov[16'h0000] = 8'h12;
    run_one(8'hA1, 16'h0400, 8'h00, 8'h01, 8'h00, 0);
    // R9: pointer at 0xFF with Y carry into high byte
    ov[16'h0500] = 8'hFF; ov[16'h00FF] = 8'hF0; ov[16'h0000] = 8'h12;
    run_one(8'hB1, 16'h0500, 8'h00, 8'h00, 8'h20, 0);
    // R6: absolute + X wraps past 0xFFFF
    ov[16'h0600] = 8'hFF; ov[16'h0601] = 8'hFF;
    run_one(8'hBD, 16'h0600, 8'h00, 8'h02, 8'h00, 0);
    // R6: absolute + Y page crossing
    ov[16'h0900] = 8'h90; ov[16'h0901] = 8'h12;
    run_one(8'hBE, 16'h0900, 8'h00, 8'h00, 8'h80, 0);
    // R7: indirect pointer at page end, second byte from next page
    ov[16'h0700] = 8'hFF; ov[16'h0701] = 8'h10; ov[16'h10FF] = 8'h78; ov[16'h1100] = 8'h56;
    run_one(8'h6C, 16'h0700, 8'h00, 8'h00, 8'h00, 0);
    // R10: most negative offset, and a forward offset wrapping past 0xFFFF
    ov[16'h0800] = 8'h80;
    run_one(8'h30, 16'h0800, 8'h00, 8'h00, 8'h00, 0);
    ov[16'hFFFE] = 8'h05;
    run_one(8'hD0, 16'hFFFE, 8'h00, 8'h00, 8'h00, 0);
    // R4: immediate at the top of memory, pc wraps
    run_one(8'hA9, 16'hFFFF, 8'h00, 8'h00, 8'h00, 0);
    // R3: accumulator
    run_one(8'h0A, 16'h4000, 8'h77, 8'h01, 8'h02, 0);
    // R2: invalid and implied
    run_one(8'hFF, 16'h4100, 8'h11, 8'h22, 8'h33, 0);
    run_one(8'hEA, 16'h4200, 8'h11, 8'h22, 8'h33, 0);
    // R12: start pokes while busy
    run_one(8'h6C, 16'h0700, 8'h00, 8'h00, 8'h00, 3);
    run_one(8'hA5, 16'h2345, 8'h00, 8'h00, 8'h00, 2);
    run_one(8'hB1, 16'h0500, 8'h00, 8'h00, 8'h20, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule